// File: doc/BRIEF.md
# XOR-Encoded Two-Write Two-Read Memory

This block is a word-addressed memory with two independent write ports and two independent read ports, all active in the same clock cycle. It does not track which port last wrote each address, and it has no multiplexer that picks a bank for a read. Each write port owns a bank. The word a port stores is its new data XORed with what the other port's bank holds at that address. A read therefore returns the XOR of the two banks at the read address.

Every bank is kept in three identical copies, all written together:
- one copy for each external read port;
- one copy for the read-modify-write lookup made by the opposite write port.

A write is pipelined over two cycles. In the first cycle the old word of the opposite bank is captured. In the second cycle the encoded word is stored. Each port can take a new write every cycle. Forwarding of staged encoded words keeps both the write lookups and the external reads coherent while a write is still in flight.

Reads are registered: an address presented before a clock edge yields its data after that edge. A read sees every write accepted at earlier edges. It does not see a write accepted at the same edge.

Top module: `xor_mport_mem`

## Requirements
- R1: A synchronous active-high reset clears every bank copy and both read-data registers, so every address then reads as zero.
- R2: Each read port returns, one clock edge after its address is sampled, the most recent data written to that address by writes accepted at earlier edges; this holds under arbitrary mixed traffic.
- R3: Data written by either port is returned by a read of that address two or more cycles later.
- R4: A read sampled at the edge right after a write was accepted returns the new data (served from the staged write).
- R5: A read sampled at the same edge as a write to the same address returns the previous contents.
- R6: Each write port accepts a new write every cycle, with no stall, and all back-to-back writes land.
- R7: When one port writes an address and the other port writes the same address in the next cycle, the later write's data is what reads return.
- R8: When both ports write the same address at the same edge, port 1's data is what reads return.
- R9: A write port with its enable low leaves the memory unchanged whatever its address and data inputs carry.
- R10: The two read ports read independent addresses, and they return equal data when given the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr0_en | input | 1 | Write port 0 enable |
| wr0_addr | input | $clog2(DEPTH) | Write port 0 address |
| wr0_data | input | DATA_W | Write port 0 data |
| wr1_en | input | 1 | Write port 1 enable (wins on same-edge same-address collision) |
| wr1_addr | input | $clog2(DEPTH) | Write port 1 address |
| wr1_data | input | DATA_W | Write port 1 data |
| rd0_addr | input | $clog2(DEPTH) | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 data, registered |
| rd1_addr | input | $clog2(DEPTH) | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 data, registered |

## Verification
Directed patterns place reads at zero, one and two or more cycles after a write. This separates the stale-data case, the bypass path and the committed path. Cross-port writes to one address are applied in three forms:
- in consecutive cycles, in both orders, which shows whether the pending encoded word is forwarded into the other port's lookup;
- in the same cycle, which shows the port-1 priority;
- as a same-cycle collision followed by a further write, which shows forwarding of a collision-encoded word.

A long random run confined mostly to four addresses then packs collisions, bypasses and back-to-back writes densely. Every cycle of that run is compared with a flat reference array.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

    // Port counts are fixed by the architecture; replica count follows from them.
    localparam int unsigned N_WR    = 2;
    localparam int unsigned N_RD    = 2;
    localparam int unsigned N_REP   = N_RD + N_WR - 1;
    // Replica index reserved for the opposite write port's lookup.
    localparam int unsigned REP_RMW = N_RD;

    // Which word a staged write XORs its data with.
    typedef enum logic [0:0] {
        ENC_OWN_OLD = 1'b0,   // the captured word of the opposite bank
        ENC_PARTNER = 1'b1    // the opposite port's encoded word staged alongside
    } enc_src_e;

endpackage

// File: rtl/xmp_bank_replica.sv
module xmp_bank_replica #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(DEPTH); i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

    // R3: a committed word is present at its address after the edge
    a_r3_word_committed: assert property (@(posedge clk) disable iff (rst)
        ($past(we) && !$past(rst)) |-> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/xmp_bank_group.sv
module xmp_bank_group #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned NREP   = 3,
    parameter int unsigned AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        we,
    input  logic [AW-1:0]               waddr,
    input  logic [DATA_W-1:0]           wdata,
    input  logic [NREP-1:0][AW-1:0]     raddr,
    output logic [NREP-1:0][DATA_W-1:0] rdata
);

    for (genvar r = 0; r < int'(NREP); r++) begin : g_rep
        xmp_bank_replica #(
            .DATA_W (DATA_W),
            .DEPTH  (DEPTH),
            .AW     (AW)
        ) u_rep (
            .clk   (clk),
            .rst   (rst),
            .we    (we),
            .waddr (waddr),
            .wdata (wdata),
            .raddr (raddr[r]),
            .rdata (rdata[r])
        );

        if (r > 0) begin : g_chk
            // R10: every copy of a bank holds the same contents
            a_r10_copies_agree: assert property (@(posedge clk) disable iff (rst)
                (raddr[r] == raddr[0]) |-> (rdata[r] == rdata[0]));
        end
    end

endmodule

// File: rtl/xmp_wr_lane.sv
module xmp_wr_lane
    import xmp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned AW     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_we,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic [DATA_W-1:0] req_old,      // opposite bank word, already forwarded
    input  enc_src_e          req_src,
    input  logic [DATA_W-1:0] partner_enc,  // opposite port's staged encoded word
    output logic              st_we,
    output logic [AW-1:0]     st_addr,
    output logic [DATA_W-1:0] st_enc
);

    typedef struct packed {
        logic              we;
        logic [AW-1:0]     addr;
        logic [DATA_W-1:0] data;
        logic [DATA_W-1:0] old;
        enc_src_e          src;
    } stage_t;

    stage_t st_q;

    // First cycle: capture request plus the looked-up opposite word.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= '{we: req_we, addr: req_addr, data: req_data,
                      old: req_old, src: req_src};
        end
    end

    // Second cycle: form the word the own bank stores.
    always_comb begin
        st_we   = st_q.we;
        st_addr = st_q.addr;
        st_enc  = st_q.data ^ ((st_q.src == ENC_PARTNER) ? partner_enc : st_q.old);
    end

endmodule

// File: rtl/xor_mport_mem.sv
module xor_mport_mem
    import xmp_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned DEPTH  = 16,
    localparam int unsigned AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr0_en,
    input  logic [AW-1:0]     wr0_addr,
    input  logic [DATA_W-1:0] wr0_data,
    input  logic              wr1_en,
    input  logic [AW-1:0]     wr1_addr,
    input  logic [DATA_W-1:0] wr1_data,
    input  logic [AW-1:0]     rd0_addr,
    output logic [DATA_W-1:0] rd0_data,
    input  logic [AW-1:0]     rd1_addr,
    output logic [DATA_W-1:0] rd1_data
);

    logic [N_REP-1:0][AW-1:0]     b0_raddr, b1_raddr;
    logic [N_REP-1:0][DATA_W-1:0] b0_rdata, b1_rdata;

    logic              st0_we, st1_we;
    logic [AW-1:0]     st0_addr, st1_addr;
    logic [DATA_W-1:0] enc0, enc1;
    logic [DATA_W-1:0] old0, old1;
    enc_src_e          src1;

    logic [N_RD-1:0][AW-1:0]     ext_addr;
    logic [N_RD-1:0][DATA_W-1:0] rd_nxt, rd_q;

    assign ext_addr = {rd1_addr, rd0_addr};

    // Replica N_RD of each bank serves the opposite write port's lookup.
    assign b0_raddr = {wr1_addr, ext_addr};
    assign b1_raddr = {wr0_addr, ext_addr};

    xmp_bank_group #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NREP(N_REP), .AW(AW)) u_bank0 (
        .clk   (clk),
        .rst   (rst),
        .we    (st0_we),
        .waddr (st0_addr),
        .wdata (enc0),
        .raddr (b0_raddr),
        .rdata (b0_rdata)
    );

    xmp_bank_group #(.DATA_W(DATA_W), .DEPTH(DEPTH), .NREP(N_REP), .AW(AW)) u_bank1 (
        .clk   (clk),
        .rst   (rst),
        .we    (st1_we),
        .waddr (st1_addr),
        .wdata (enc1),
        .raddr (b1_raddr),
        .rdata (b1_rdata)
    );

    // Lookup of the opposite bank, with the word it is about to commit forwarded.
    always_comb begin
        old0 = (st1_we && (st1_addr == wr0_addr)) ? enc1 : b1_rdata[REP_RMW];
        old1 = (st0_we && (st0_addr == wr1_addr)) ? enc0 : b0_rdata[REP_RMW];
        // Same-edge same-address: port 1 encodes against port 0's new word.
        src1 = (wr0_en && wr1_en && (wr0_addr == wr1_addr)) ? ENC_PARTNER : ENC_OWN_OLD;
    end

    xmp_wr_lane #(.DATA_W(DATA_W), .AW(AW)) u_lane0 (
        .clk         (clk),
        .rst         (rst),
        .req_we      (wr0_en),
        .req_addr    (wr0_addr),
        .req_data    (wr0_data),
        .req_old     (old0),
        .req_src     (ENC_OWN_OLD),
        .partner_enc ('0),
        .st_we       (st0_we),
        .st_addr     (st0_addr),
        .st_enc      (enc0)
    );

    xmp_wr_lane #(.DATA_W(DATA_W), .AW(AW)) u_lane1 (
        .clk         (clk),
        .rst         (rst),
        .req_we      (wr1_en),
        .req_addr    (wr1_addr),
        .req_data    (wr1_data),
        .req_old     (old1),
        .req_src     (src1),
        .partner_enc (enc0),
        .st_we       (st1_we),
        .st_addr     (st1_addr),
        .st_enc      (enc1)
    );

    // External reads: XOR of both banks, staged writes bypassed in.
    for (genvar r = 0; r < int'(N_RD); r++) begin : g_rd
        logic [DATA_W-1:0] w0, w1;
        always_comb begin
            w0        = (st0_we && (st0_addr == ext_addr[r])) ? enc0 : b0_rdata[r];
            w1        = (st1_we && (st1_addr == ext_addr[r])) ? enc1 : b1_rdata[r];
            rd_nxt[r] = w0 ^ w1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_q <= '0;
        else     rd_q <= rd_nxt;
    end

    assign rd0_data = rd_q[0];
    assign rd1_data = rd_q[1];

    // R1: first cycle out of reset presents zero on both read ports
    a_r1_reset_reads_zero: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (rd0_data == '0 && rd1_data == '0));

    // R8: a same-edge collision decodes to port 1's data
    a_r8_collision_port1_wins: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr0_en && wr1_en && (wr0_addr == wr1_addr)))
        |-> ((enc0 ^ enc1) == $past(wr1_data)));

    // R6: an accepted write is staged for commit in the following cycle
    a_r6_write_staged: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(wr1_en)) |-> (st1_we && st1_addr == $past(wr1_addr)));

endmodule

// File: tb/xor_mport_mem_tb.sv
module xor_mport_mem_tb;

    localparam int DW = 8;
    localparam int DP = 16;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr0_en, wr1_en;
    logic [AW-1:0] wr0_addr, wr1_addr, rd0_addr, rd1_addr;
    logic [DW-1:0] wr0_data, wr1_data, rd0_data, rd1_data;

    always #10 clk = ~clk;   // 50 MHz

    xor_mport_mem #(.DATA_W(DW), .DEPTH(DP)) u_dut (
        .clk      (clk),
        .rst      (rst),
        .wr0_en   (wr0_en),
        .wr0_addr (wr0_addr),
        .wr0_data (wr0_data),
        .wr1_en   (wr1_en),
        .wr1_addr (wr1_addr),
        .wr1_data (wr1_data),
        .rd0_addr (rd0_addr),
        .rd0_data (rd0_data),
        .rd1_addr (rd1_addr),
        .rd1_data (rd1_data)
    );

    // Behavioural reference: flat array, reads see writes of earlier edges only.
    logic [DW-1:0] ref_mem [DP];
    logic [DW-1:0] exp0, exp1;
    bit            exp_ok = 0;
    string         tag = "R1";
    string         tag_q = "R1";
    int            n_cmp = 0;
    int            n_bad = 0;
    bit            done = 0;

    always @(posedge clk) begin
        tag_q = tag;
        if (rst) begin
            for (int i = 0; i < DP; i++) ref_mem[i] = '0;
            exp0 = '0;
            exp1 = '0;
        end else begin
            exp0 = ref_mem[rd0_addr];
            exp1 = ref_mem[rd1_addr];
            if (wr0_en) ref_mem[wr0_addr] = wr0_data;
            if (wr1_en) ref_mem[wr1_addr] = wr1_data;   // R8: port 1 applied last
        end
        exp_ok = 1;
    end

    always @(negedge clk) begin
        if (exp_ok && !done) begin
            n_cmp++;
            if (rd0_data !== exp0) begin
                n_bad++;
                $display("FAIL %s rd0 t=%0t got %h exp %h", tag_q, $time, rd0_data, exp0);
            end
            n_cmp++;
            if (rd1_data !== exp1) begin
                n_bad++;
                $display("FAIL %s rd1 t=%0t got %h exp %h", tag_q, $time, rd1_data, exp1);
            end
        end
    end

    task automatic step(input logic e0, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                        input logic e1, input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                        input logic [AW-1:0] r0, input logic [AW-1:0] r1, input string t);
        @(negedge clk);
        wr0_en = e0; wr0_addr = a0; wr0_data = d0;
        wr1_en = e1; wr1_addr = a1; wr1_data = d1;
        rd0_addr = r0; rd1_addr = r1;
        tag = t;
    endtask

    task automatic rd(input logic [AW-1:0] r0, input logic [AW-1:0] r1, input string t);
        step(0, 0, 8'h00, 0, 0, 8'h00, r0, r1, t);
    endtask

    task automatic summary();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        $display("FAIL watchdog expired got hang exp completion");
        n_bad++;
        n_cmp++;
        summary();
    end

    initial begin
        rst = 1;
        wr0_en = 0; wr1_en = 0;
        wr0_addr = 0; wr1_addr = 0; wr0_data = 0; wr1_data = 0;
        rd0_addr = 0; rd1_addr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: every address reads zero after reset
        for (int i = 0; i < DP / 2; i++) rd(AW'(i), AW'(i + DP / 2), "R1");

        // R3: committed write read later
        step(1, 3, 8'hA5, 0, 0, 8'h00, 0, 0, "R3");
        rd(0, 0, "R3");
        rd(3, 3, "R3");
        rd(3, 3, "R3");

        // R4: read at the edge right after the write (bypass)
        step(1, 5, 8'h3C, 1, 6, 8'hC3, 0, 0, "R4");
        rd(5, 6, "R4");

        // R5: read at the same edge as the write sees old data
        step(1, 7, 8'h11, 0, 0, 8'h00, 7, 3, "R5");
        rd(7, 7, "R5");

        // R7: port 0 then port 1 on one address, then the reverse order
        step(1, 9, 8'h22, 0, 0, 8'h00, 9, 9, "R7");
        step(0, 0, 8'h00, 1, 9, 8'h44, 9, 9, "R7");
        rd(9, 9, "R7");
        rd(9, 9, "R7");
        step(0, 0, 8'h00, 1, 10, 8'h55, 10, 10, "R7");
        step(1, 10, 8'h66, 0, 0, 8'h00, 10, 10, "R7");
        rd(10, 10, "R7");
        rd(10, 10, "R7");

        // R8: same-edge collision, then a collision followed by another write
        step(1, 12, 8'hAA, 1, 12, 8'hBB, 12, 12, "R8");
        rd(12, 12, "R8");
        rd(12, 12, "R8");
        step(1, 12, 8'h01, 1, 12, 8'h02, 12, 12, "R8");
        step(1, 12, 8'h03, 0, 0, 8'h00, 12, 12, "R8");
        step(0, 0, 8'h00, 1, 12, 8'h04, 12, 12, "R8");
        rd(12, 12, "R8");
        rd(12, 12, "R8");

        // R9: disabled write ports change nothing
        step(0, 3, 8'hFF, 0, 5, 8'hFF, 3, 5, "R9");
        rd(3, 5, "R9");
        rd(3, 5, "R9");

        // R6: a write on each port every cycle
        for (int i = 0; i < 8; i++)
            step(1, AW'(i), DW'(8'h80 + i), 1, AW'(i + 8), DW'(8'h40 + i),
                 AW'(i), AW'(i + 8), "R6");
        for (int i = 0; i < 8; i++) rd(AW'(i), AW'(i + 8), "R6");

        // R10: both read ports on the same addresses
        for (int i = 0; i < DP; i++) rd(AW'(i), AW'(i), "R10");

        // R2: random traffic, mostly on four addresses to force overlaps
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] m;
            m = (i % 5 == 0) ? AW'(4'hF) : AW'(4'h3);
            step(1'($urandom), AW'($urandom) & m, DW'($urandom),
                 1'($urandom), AW'($urandom) & m, DW'($urandom),
                 AW'($urandom) & m, AW'($urandom) & m, "R2");
        end
        rd(0, 1, "R2");
        rd(2, 3, "R2");
        @(negedge clk);
        @(negedge clk);
        summary();
    end

endmodule